// File: doc/BRIEF.md
# Hub Status Change Interrupt Endpoint

This block owns the one-byte change bitmap that a USB hub returns on its interrupt endpoint, and decides how each IN token addressed to that endpoint is answered. A local frame timer, advanced by a 12 MHz bit-rate clock enable and restarted by every received start-of-frame token, marks a sampling point shortly before each frame ends. At that point the hub-level and per-port change flags are copied into the bitmap. The copy is then ready for a poll during the next frame.

When an IN token arrives, the block answers one cycle later with a response code and a payload. The response is DATA with the whole byte when any hub or port bit is set, and NAK when the bitmap is empty. The change flags are level inputs that the surrounding hub logic holds until the host clears them. A change therefore goes on being reported every frame until it is cleared. While the hub is not configured, the bitmap stays empty and every poll is refused with NAK. A single data toggle bit follows the acknowledged DATA responses.

Top module: `hub_chg_intr_ep`

## Requirements
- R1: The frame timer advances only on cycles with `bit_en` high, and `sof_rx` restarts it from zero. If start-of-frame tokens arrive more often than the sampling count, no sampling takes place.
- R2: The bitmap is loaded only at the sampling point, which is the clock edge that ends the cycle in which the timer holds `EOF2_POINT` (default 11990) with `bit_en` high. Flag changes made after that edge wait for the next sampling point.
- R3: Bitmap layout: bit 0 is the hub change, bit i (1 to `NUM_PORTS`) is port i's change (`port_chg[i-1]`), and the bits above `NUM_PORTS` are always zero.
- R4: An IN token with an all-zero bitmap is answered with NAK (`resp_data`=0) and a zero payload.
- R5: An IN token with any bit 0..`NUM_PORTS` set is answered with DATA (`resp_data`=1) and the full bitmap byte as payload. `resp_valid` is high for exactly the cycle after the `in_tok` cycle.
- R6: A change that stays set is reported again on every poll in every later frame, until its flag is cleared and a sampling point has passed.
- R7: While `configured` is low, the bitmap is held at zero and every poll is answered with NAK. After configuration, nothing is reported before the next sampling point.
- R8: Without start-of-frame tokens, the timer wraps from `FRAME_LEN-1` (default 11999) to zero, so sampling recurs every `FRAME_LEN` enabled counts.
- R9: The toggle bit starts at 0 (DATA0). It flips on an `ack_rx` that follows a DATA response, is unchanged by an `ack_rx` after a NAK or a repeated `ack_rx`, and is forced to 0 while `configured` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | 12 MHz bit-rate clock enable |
| sof_rx | input | 1 | Start-of-frame token received, one-cycle strobe |
| configured | input | 1 | Hub has been configured by the host |
| hub_chg | input | 1 | Hub-level change flag (level) |
| port_chg | input | NUM_PORTS | Per-port change flags, bit i-1 for port i (level) |
| in_tok | input | 1 | IN token for the interrupt endpoint, one-cycle strobe |
| ack_rx | input | 1 | Host handshake acknowledging the last data packet |
| resp_valid | output | 1 | Response is valid this cycle |
| resp_data | output | 1 | 1 = DATA, 0 = NAK |
| payload | output | MAP_W | Bitmap byte sent with DATA, zero with NAK |
| toggle | output | 1 | Data toggle to use for the next DATA packet |

## Verification
A wrong timer count or a lost restart shows up as a change that is reported one frame too early, one frame too late, or never. Polls placed one cycle on each side of the sampling edge, and polls made under frequent start-of-frame tokens, expose this within a single frame. A stale or corrupted bitmap shows up at the very next poll as a wrong response code or a wrong payload byte. A toggle error shows up right after the acknowledge handshake.

// File: rtl/hce_pkg.sv
package hce_pkg;
   typedef enum logic {
      HCE_NAK  = 1'b0,
      HCE_DATA = 1'b1
   } hce_resp_e;

   function automatic int hce_cnt_width(input int frame_len);
      return (frame_len <= 2) ? 1 : $clog2(frame_len);
   endfunction
endpackage

// File: rtl/hce_frame_timer.sv
module hce_frame_timer #(
   parameter int FRAME_LEN  = 12000,
   parameter int EOF2_POINT = 11990
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic sof_rx,
   output logic eof2_stb
);
   localparam int CW = hce_pkg::hce_cnt_width(FRAME_LEN);
   localparam logic [CW-1:0] LAST_CNT = CW'(FRAME_LEN - 1);
   localparam logic [CW-1:0] EOF2_CNT = CW'(EOF2_POINT);

   if (FRAME_LEN < 2) begin : g_bad_len
      $error("FRAME_LEN must be at least 2");
   end
   if (EOF2_POINT >= FRAME_LEN || EOF2_POINT < 0) begin : g_bad_eof2
      $error("EOF2_POINT must lie inside the frame");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (sof_rx) begin
         cnt_q <= '0;
      end else if (bit_en) begin
         cnt_q <= (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
      end
   end

   assign eof2_stb = bit_en && !sof_rx && (cnt_q == EOF2_CNT);

   // R1: a start-of-frame token restarts the count
   a_r1_sof_restart : assert property (@(posedge clk) disable iff (!rst_n)
      sof_rx |=> (cnt_q == '0));
   // R1: no enable, no progress
   a_r1_stall : assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_en && !sof_rx) |=> $stable(cnt_q));
   // R8: wrap at the end of the frame
   a_r8_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !sof_rx && cnt_q == LAST_CNT) |=> (cnt_q == '0));
endmodule

// File: rtl/hce_change_map.sv
module hce_change_map #(
   parameter int NUM_PORTS = 4,
   parameter int MAP_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 eof2_stb,
   input  logic                 configured,
   input  logic                 hub_chg,
   input  logic [NUM_PORTS-1:0] port_chg,
   output logic [MAP_W-1:0]     bitmap
);
   if (NUM_PORTS < 1 || NUM_PORTS + 1 > MAP_W) begin : g_bad_ports
      $error("NUM_PORTS must be 1..MAP_W-1");
   end

   logic [MAP_W-1:0] flags_now;

   for (genvar b = 0; b < MAP_W; b++) begin : g_bit
      if (b == 0) begin : g_hub
         assign flags_now[b] = hub_chg;
      end else if (b <= NUM_PORTS) begin : g_port
         assign flags_now[b] = port_chg[b-1];
      end else begin : g_rsvd
         assign flags_now[b] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitmap <= '0;
      end else if (!configured) begin
         bitmap <= '0;
      end else if (eof2_stb) begin
         bitmap <= flags_now;
      end
   end

   // R2: the bitmap only moves at the sampling point
   a_r2_hold_between : assert property (@(posedge clk) disable iff (!rst_n)
      (configured && !eof2_stb) |=> $stable(bitmap));
   // R7: unconfigured hub keeps an empty bitmap
   a_r7_empty_unconf : assert property (@(posedge clk) disable iff (!rst_n)
      !configured |=> (bitmap == '0));
endmodule

// File: rtl/hce_in_responder.sv
module hce_in_responder #(
   parameter int NUM_PORTS = 4,
   parameter int MAP_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             configured,
   input  logic [MAP_W-1:0] bitmap,
   input  logic             in_tok,
   input  logic             ack_rx,
   output logic             resp_valid,
   output logic             resp_data,
   output logic [MAP_W-1:0] payload,
   output logic             toggle
);
   import hce_pkg::*;

   hce_resp_e kind_now;
   logic      ack_pend_q;

   always_comb begin
      kind_now = (configured && (|bitmap[NUM_PORTS:0])) ? HCE_DATA : HCE_NAK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_data  <= 1'b0;
         payload    <= '0;
      end else begin
         resp_valid <= in_tok;
         if (in_tok) begin
            resp_data <= (kind_now == HCE_DATA);
            payload   <= (kind_now == HCE_DATA) ? bitmap : '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_pend_q <= 1'b0;
         toggle     <= 1'b0;
      end else if (!configured) begin
         ack_pend_q <= 1'b0;
         toggle     <= 1'b0;
      end else if (in_tok) begin
         ack_pend_q <= (kind_now == HCE_DATA);
      end else if (ack_rx) begin
         ack_pend_q <= 1'b0;
         if (ack_pend_q) toggle <= ~toggle;
      end
   end

   // R5: a non-empty bitmap on a configured hub yields DATA next cycle
   a_r5_data_resp : assert property (@(posedge clk) disable iff (!rst_n)
      (in_tok && configured && (|bitmap[NUM_PORTS:0])) |=> (resp_valid && resp_data));
   // R4: a NAK carries no payload
   a_r4_nak_empty : assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_data) |-> (payload == '0));
   // R7: no DATA out of an unconfigured hub
   a_r7_nak_unconf : assert property (@(posedge clk) disable iff (!rst_n)
      !configured |=> !(resp_valid && resp_data));
   // R9: toggle is DATA0 while unconfigured
   a_r9_toggle_clear : assert property (@(posedge clk) disable iff (!rst_n)
      !configured |=> !toggle);
   // R9: toggle moves only on a handshake
   a_r9_toggle_on_ack : assert property (@(posedge clk) disable iff (!rst_n)
      (configured && !ack_rx) |=> $stable(toggle));
endmodule

// File: rtl/hub_chg_intr_ep.sv
module hub_chg_intr_ep #(
   parameter int NUM_PORTS  = 4,
   parameter int MAP_W      = 8,
   parameter int FRAME_LEN  = 12000,
   parameter int EOF2_POINT = 11990
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_en,
   input  logic                 sof_rx,
   input  logic                 configured,
   input  logic                 hub_chg,
   input  logic [NUM_PORTS-1:0] port_chg,
   input  logic                 in_tok,
   input  logic                 ack_rx,
   output logic                 resp_valid,
   output logic                 resp_data,
   output logic [MAP_W-1:0]     payload,
   output logic                 toggle
);
   logic             eof2_stb;
   logic [MAP_W-1:0] bitmap;

   hce_frame_timer #(
      .FRAME_LEN (FRAME_LEN),
      .EOF2_POINT(EOF2_POINT)
   ) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_en  (bit_en),
      .sof_rx  (sof_rx),
      .eof2_stb(eof2_stb)
   );

   hce_change_map #(
      .NUM_PORTS(NUM_PORTS),
      .MAP_W    (MAP_W)
   ) i_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .eof2_stb  (eof2_stb),
      .configured(configured),
      .hub_chg   (hub_chg),
      .port_chg  (port_chg),
      .bitmap    (bitmap)
   );

   hce_in_responder #(
      .NUM_PORTS(NUM_PORTS),
      .MAP_W    (MAP_W)
   ) i_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .configured(configured),
      .bitmap    (bitmap),
      .in_tok    (in_tok),
      .ack_rx    (ack_rx),
      .resp_valid(resp_valid),
      .resp_data (resp_data),
      .payload   (payload),
      .toggle    (toggle)
   );

   // R3: bits above the port range never leave the block set
   a_r3_rsvd_zero : assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (payload[MAP_W-1:NUM_PORTS+1] == '0));
   // R5: one response per token
   a_r5_one_resp : assert property (@(posedge clk) disable iff (!rst_n)
      !in_tok |=> !resp_valid);
endmodule

// File: tb/test_hub_chg_intr_ep.sv
module test_hub_chg_intr_ep;
   localparam int NP = 4;
   localparam int MW = 8;
   localparam int FL = 64;
   localparam int EP = 54;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b1;
   logic sof_rx = 1'b0;
   logic configured = 1'b0;
   logic hub_chg = 1'b0;
   logic [NP-1:0] port_chg = '0;
   logic in_tok = 1'b0;
   logic ack_rx = 1'b0;
   logic resp_valid, resp_data, toggle;
   logic [MW-1:0] payload;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 0;

   logic          q_kind[$];
   logic [MW-1:0] q_pay[$];
   string         q_tag[$];

   always #10 clk = ~clk;

   hub_chg_intr_ep #(.NUM_PORTS(NP), .MAP_W(MW), .FRAME_LEN(FL), .EOF2_POINT(EP)) i_hub_chg_intr_ep (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sof_rx(sof_rx),
      .configured(configured), .hub_chg(hub_chg), .port_chg(port_chg),
      .in_tok(in_tok), .ack_rx(ack_rx), .resp_valid(resp_valid),
      .resp_data(resp_data), .payload(payload), .toggle(toggle));

   // monitor: pops expected responses
   always @(negedge clk) begin
      if (rst_n && resp_valid) begin
         checks++;
         if (q_kind.size() == 0) begin
            fails++;
            $display("FAIL R5 unexpected response data=%0b payload=%02h expected none", resp_data, payload);
         end else begin
            logic          ek;
            logic [MW-1:0] ep;
            string         et;
            ek = q_kind.pop_front();
            ep = q_pay.pop_front();
            et = q_tag.pop_front();
            if (resp_data !== ek || payload !== ep) begin
               fails++;
               $display("FAIL %s response data=%0b payload=%02h expected data=%0b payload=%02h",
                        et, resp_data, payload, ek, ep);
            end
         end
      end
   end

   task automatic poll(input logic kind, input logic [MW-1:0] pay, input string tag);
      @(negedge clk);
      q_kind.push_back(kind);
      q_pay.push_back(pay);
      q_tag.push_back(tag);
      in_tok = 1'b1;
      @(negedge clk);
      in_tok = 1'b0;
      @(negedge clk);
   endtask

   task automatic frame_start();
      @(negedge clk);
      sof_rx = 1'b1;
      @(negedge clk);
      sof_rx = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ack();
      @(negedge clk);
      ack_rx = 1'b1;
      @(negedge clk);
      ack_rx = 1'b0;
   endtask

   task automatic check_tog(input logic exp, input string tag);
      checks++;
      if (toggle !== exp) begin
         fails++;
         $display("FAIL %s toggle=%0b expected %0b", tag, toggle, exp);
      end
   endtask

   task automatic finish_run();
      if (q_kind.size() != 0) begin
         checks++;
         fails++;
         $display("FAIL R5 missing responses=%0d expected 0", q_kind.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog cycles=%0d expected completion", cycles);
         finish_run();
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // reset state
      poll(1'b0, 8'h00, "R7 reset");
      check_tog(1'b0, "R9 reset");
      // unconfigured hub refuses
      port_chg = 4'b0010;
      idle(2 * FL + 5);
      poll(1'b0, 8'h00, "R7 unconfigured");
      // configure; not reported before sampling
      configured = 1'b1;
      frame_start();
      idle(10);
      poll(1'b0, 8'h00, "R2 before sampling");
      idle(60);
      poll(1'b1, 8'h04, "R5 port2 bit2");
      for (int i = 0; i < 3; i++) begin
         idle(FL);
         poll(1'b1, 8'h04, "R6 repeated report");
      end
      // toggle
      ack();
      @(negedge clk);
      check_tog(1'b1, "R9 ack after DATA");
      ack();
      @(negedge clk);
      check_tog(1'b1, "R9 repeated ack");
      // clearing takes effect at next sampling
      frame_start();
      idle(5);
      port_chg = 4'b0000;
      idle(4);
      poll(1'b1, 8'h04, "R6 still reported until sampling");
      idle(60);
      poll(1'b0, 8'h00, "R4 empty after clear");
      ack();
      @(negedge clk);
      check_tog(1'b1, "R9 ack after NAK");
      // layout
      hub_chg = 1'b1;
      port_chg = 4'b1001;
      frame_start();
      idle(70);
      poll(1'b1, 8'h13, "R3 hub port1 port4");
      port_chg = 4'b1111;
      frame_start();
      idle(70);
      poll(1'b1, 8'h1F, "R3 all bits");
      // sampling edge boundary
      hub_chg = 1'b0;
      port_chg = 4'b0000;
      frame_start();
      idle(70);
      frame_start();
      idle(EP + 1);
      port_chg = 4'b0100;
      idle(2);
      poll(1'b0, 8'h00, "R2 flag after sampling edge missed");
      idle(FL);
      poll(1'b1, 8'h08, "R8 wrap resamples");
      port_chg = 4'b0000;
      frame_start();
      idle(70);
      poll(1'b0, 8'h00, "R4 cleared again");
      frame_start();
      idle(EP);
      port_chg = 4'b0100;
      idle(5);
      poll(1'b1, 8'h08, "R2 flag just before sampling edge");
      // frequent SOF holds sampling off
      port_chg = 4'b0000;
      frame_start();
      idle(70);
      hub_chg = 1'b1;
      for (int i = 0; i < 6; i++) begin
         frame_start();
         idle(40);
      end
      poll(1'b0, 8'h00, "R1 frequent SOF");
      frame_start();
      bit_en = 1'b0;
      idle(100);
      poll(1'b0, 8'h00, "R1 stalled timer");
      bit_en = 1'b1;
      idle(60);
      poll(1'b1, 8'h01, "R1 resumes after stall");
      // deconfigure / reconfigure
      configured = 1'b0;
      idle(2);
      check_tog(1'b0, "R9 cleared on deconfigure");
      poll(1'b0, 8'h00, "R7 deconfigured");
      configured = 1'b1;
      poll(1'b0, 8'h00, "R7 nothing before sampling");
      idle(FL + 5);
      poll(1'b1, 8'h01, "R7 reported after sampling");
      idle(3);
      done = 1;
      finish_run();
   end
endmodule